// File: doc/BRIEF.md
# Float-to-Integer Conversion Unit

This unit turns one IEEE-754 operand into a signed integer. The operand is either single precision (taken from the low 32 bits of the operand bus) or double precision. The result is either a 32-bit word or a 64-bit integer. Each request selects one of four fixed rounding kinds, or asks for the rounding mode held in a small control register. The result and its flags appear one clock after the request.

The control register also carries a mode bit that decides how invalid conversions are reported. With the bit set, a NaN gives zero and an out-of-range value saturates toward its own sign. With the bit clear, every invalid case gives the single most-positive pattern. That bit is not under software control. It always follows a static architecture-variant strap, both out of reset and after any write.

Top module: `f2i_convert`

## Requirements
- R1: After a synchronous active-low reset `out_valid` is 0. `csr_rdata` reads 0x00040000 when `strap_new_arch` is 1 and 0x00000000 when it is 0.
- R2: A write through `csr_we` stores `csr_wdata` with bit 18 replaced by the value of `strap_new_arch`. The stored value is visible on `csr_rdata` in the cycle after the write.
- R3: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, the result and the flags hold their previous values.
- R4: `in_kind` values 0, 1, 2 and 3 select, in that order, round to nearest with ties to even, toward zero, toward plus infinity and toward minus infinity. In-range results equal the operand rounded that way.
- R5: `in_kind` values 4 to 7 use the rounding mode in control bits 1:0 (0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity), taken as the register stood in the request cycle.
- R6: With `in_src_dbl`=0 only `in_operand[31:0]` is read as a single-precision value, and bits 63:32 have no effect. With `in_dst_long`=0 the two's-complement word sits in `out_result[31:0]` and `out_result[63:32]` is 0.
- R7: For a valid conversion, `out_inexact` is 1 exactly when the rounded integer differs from the operand.
- R8: With bit 18 set, a NaN operand gives result 0 with `out_invalid`=1.
- R9: With bit 18 set, a value that rounds above the most positive integer of the target width gives 0x7FFFFFFF or 0x7FFFFFFFFFFFFFFF. A value that rounds below the most negative integer gives 0x80000000 or 0x8000000000000000. Both set `out_invalid`, infinities included. The most negative integer itself converts validly.
- R10: With bit 18 clear, every invalid conversion (NaN, either infinity, either overflow) gives the positive pattern of the target width with `out_invalid`=1.
- R11: `out_invalid` and `out_inexact` are never 1 together; an invalid conversion reports `out_inexact`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_new_arch | input | 1 | Static variant strap; 1 forces 2008-style invalid handling |
| in_valid | input | 1 | Conversion request |
| in_src_dbl | input | 1 | 1: double-precision source, 0: single in bits 31:0 |
| in_dst_long | input | 1 | 1: 64-bit result, 0: 32-bit word |
| in_kind | input | 3 | Rounding kind (see R4, R5) |
| in_operand | input | 64 | Floating-point operand bits |
| csr_we | input | 1 | Control register write enable |
| csr_wdata | input | 32 | Control register write data |
| csr_rdata | output | 32 | Control register contents |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_result | output | 64 | Integer result |
| out_invalid | output | 1 | NaN, infinity or out-of-range |
| out_inexact | output | 1 | Rounded value differs from operand |

## Verification
The bench targets exact ties under nearest-even. A design that rounds ties away from zero turns 2.5 into 3 and -2.5 into -3. It also checks values just past each range end and the most negative integer of each width, where an off-by-one limit either saturates a legal -2^31 or -2^63 or lets -2^31-1 wrap to a positive word. NaN and both infinities are converted with the mode bit set and with it clear. A design that ignores the bit, or mixes up NaN with overflow, returns the wrong one of zero, the positive pattern and the negative pattern. Single-precision requests carry random upper operand bits and negative word results, so a leak of bits 63:32 into the input or the output shows up.

// File: rtl/f2i_pkg.sv
// Package: shared widths and types for the float-to-integer unit.
// Assumes a 64-bit result bus and a unified 53-bit significand for both
// source formats (single precision is widened exactly).
package f2i_pkg;
    localparam int XLEN       = 64;              // widest integer result
    localparam int WORD_W     = 32;              // narrow integer result
    localparam int MANT_W     = 53;              // significand incl. hidden bit
    localparam int EXP_W      = 13;              // signed unbiased exponent
    localparam int FIX_W      = 2 * XLEN;        // fixed point: XLEN int, XLEN frac
    localparam int SH_W       = $clog2(FIX_W);
    localparam int FRAC_SHIFT = XLEN - (MANT_W - 1);

    localparam int D_EXP = 11;
    localparam int D_FRC = 52;
    localparam int D_BIAS = 1023;
    localparam int S_EXP = 8;
    localparam int S_FRC = 23;
    localparam int S_BIAS = 127;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    typedef struct packed {
        logic                    sign;
        logic                    is_nan;
        logic                    is_inf;
        logic signed [EXP_W-1:0] exp;
        logic [MANT_W-1:0]       mant;
    } unpacked_t;
endpackage

// File: rtl/f2i_csr.sv
// Module: floating-point control/status register.
// Holds the rounding mode (bits 1:0) and the invalid-handling mode bit.
// The mode bit always mirrors the variant strap; the strap is assumed
// static while out of reset.
module f2i_csr #(
    parameter int CSR_W   = 32,
    parameter int NAN_BIT = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_new,
    input  logic             we,
    input  logic [CSR_W-1:0] wdata,
    output logic [CSR_W-1:0] q
);
    localparam logic [CSR_W-1:0] MODE_MASK = CSR_W'(1) << NAN_BIT;

    logic [CSR_W-1:0] reset_val;
    logic [CSR_W-1:0] write_val;

    // Derive reset and write values with the mode bit forced to the strap.
    always_comb begin
        reset_val = strap_new ? MODE_MASK : '0;
        write_val = (wdata & ~MODE_MASK) | (strap_new ? MODE_MASK : '0);
    end

    // Register update: reset value or forced write data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= reset_val;
        else if (we)
            q <= write_val;
    end

    p_mode_bit_strap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q[NAN_BIT] == strap_new);

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (((q ^ $past(wdata)) & ~MODE_MASK) == '0));
endmodule

// File: rtl/f2i_unpack.sv
// Module: splits a single- or double-precision operand into sign, class,
// unbiased exponent and a 53-bit significand. Single precision reads
// only operand[31:0]. Subnormals use the minimum exponent with no
// hidden bit, which keeps them exact.
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic            src_dbl,
    input  logic [XLEN-1:0] operand,
    output unpacked_t       u
);
    logic [D_EXP-1:0] dexp;
    logic [D_FRC-1:0] dfrc;
    logic [S_EXP-1:0] sexp;
    logic [S_FRC-1:0] sfrc;
    logic [D_EXP-1:0] dexp_eff;
    logic [S_EXP-1:0] sexp_eff;

    // Field extraction for both formats.
    always_comb begin
        dexp = operand[XLEN-2 -: D_EXP];
        dfrc = operand[D_FRC-1:0];
        sexp = operand[WORD_W-2 -: S_EXP];
        sfrc = operand[S_FRC-1:0];
        dexp_eff = (dexp == '0) ? D_EXP'(1) : dexp;
        sexp_eff = (sexp == '0) ? S_EXP'(1) : sexp;
    end

    // Format select and classification.
    always_comb begin
        if (src_dbl) begin
            u.sign   = operand[XLEN-1];
            u.is_nan = (dexp == '1) && (dfrc != '0);
            u.is_inf = (dexp == '1) && (dfrc == '0);
            u.exp    = $signed({{(EXP_W-D_EXP){1'b0}}, dexp_eff}) - EXP_W'(D_BIAS);
            u.mant   = {dexp != '0, dfrc};
        end else begin
            u.sign   = operand[WORD_W-1];
            u.is_nan = (sexp == '1) && (sfrc != '0);
            u.is_inf = (sexp == '1) && (sfrc == '0);
            u.exp    = $signed({{(EXP_W-S_EXP){1'b0}}, sexp_eff}) - EXP_W'(S_BIAS);
            u.mant   = {sexp != '0, sfrc, {(MANT_W-1-S_FRC){1'b0}}};
        end
    end
endmodule

// File: rtl/f2i_round.sv
// Module: aligns the significand onto a fixed-point grid, rounds per the
// selected mode, checks the target range and picks the invalid pattern.
// Purely combinational; the caller registers the outputs.
module f2i_round
    import f2i_pkg::*;
(
    input  unpacked_t       u,
    input  rmode_e          rm,
    input  logic            dst_long,
    input  logic            nan2008,
    output logic [XLEN-1:0] result,
    output logic            invalid,
    output logic            inexact
);
    localparam logic signed [EXP_W-1:0] SH_BIAS = EXP_W'(FRAC_SHIFT);
    localparam logic signed [EXP_W-1:0] SH_MIN  = EXP_W'(FRAC_SHIFT - 1);
    localparam logic signed [EXP_W-1:0] SH_MAX  = EXP_W'(XLEN - 1 + FRAC_SHIFT);

    localparam logic [XLEN:0] LIM_POS_L = (XLEN+1)'((65'd1 << (XLEN-1)) - 65'd1);
    localparam logic [XLEN:0] LIM_NEG_L = (XLEN+1)'(65'd1 << (XLEN-1));
    localparam logic [XLEN:0] LIM_POS_W = (XLEN+1)'((65'd1 << (WORD_W-1)) - 65'd1);
    localparam logic [XLEN:0] LIM_NEG_W = (XLEN+1)'(65'd1 << (WORD_W-1));

    localparam logic [XLEN-1:0] PAT_POS_L = {1'b0, {(XLEN-1){1'b1}}};
    localparam logic [XLEN-1:0] PAT_NEG_L = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] PAT_POS_W = {{(XLEN-WORD_W){1'b0}}, 1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [XLEN-1:0] PAT_NEG_W = {{(XLEN-WORD_W){1'b0}}, 1'b1, {(WORD_W-1){1'b0}}};

    logic signed [EXP_W-1:0] sh_full;
    logic                    tiny, huge;
    logic [FIX_W-1:0]        fixed;
    logic [XLEN-1:0]         ipart;
    logic                    half, sticky, up;
    logic [XLEN:0]           mag;
    logic [XLEN:0]           lim_pos, lim_neg;
    logic                    over;
    logic [XLEN-1:0]         sval;
    logic [XLEN-1:0]         pat_pos, pat_neg;

    // Alignment: integer part, half bit and sticky OR of the rest.
    always_comb begin
        sh_full = u.exp + SH_BIAS;
        tiny    = sh_full < SH_MIN;
        huge    = sh_full > SH_MAX;
        fixed   = {{(FIX_W-MANT_W){1'b0}}, u.mant} << sh_full[SH_W-1:0];
        if (tiny) begin
            ipart  = '0;
            half   = 1'b0;
            sticky = |u.mant;
        end else begin
            ipart  = fixed[FIX_W-1:XLEN];
            half   = fixed[XLEN-1];
            sticky = |fixed[XLEN-2:0];
        end
    end

    // Rounding increment decision per mode, on the magnitude.
    always_comb begin
        unique case (rm)
            RM_NEAR: up = half & (sticky | ipart[0]);
            RM_ZERO: up = 1'b0;
            RM_UP:   up = ~u.sign & (half | sticky);
            RM_DOWN: up =  u.sign & (half | sticky);
            default: up = 1'b0;
        endcase
        mag = {1'b0, ipart} + {{XLEN{1'b0}}, up};
    end

    // Range check against the signed limits of the target width.
    always_comb begin
        lim_pos = dst_long ? LIM_POS_L : LIM_POS_W;
        lim_neg = dst_long ? LIM_NEG_L : LIM_NEG_W;
        pat_pos = dst_long ? PAT_POS_L : PAT_POS_W;
        pat_neg = dst_long ? PAT_NEG_L : PAT_NEG_W;
        over    = huge | (u.sign ? (mag > lim_neg) : (mag > lim_pos));
        sval    = XLEN'(u.sign ? (~mag + 1'b1) : mag);
    end

    // Final selection between the legal result and the invalid patterns.
    always_comb begin
        invalid = u.is_nan | u.is_inf | over;
        inexact = ~invalid & (half | sticky);
        if (!invalid)
            result = dst_long ? sval : {{(XLEN-WORD_W){1'b0}}, sval[WORD_W-1:0]};
        else if (!nan2008)
            result = pat_pos;
        else if (u.is_nan)
            result = '0;
        else
            result = u.sign ? pat_neg : pat_pos;
    end
endmodule

// File: rtl/f2i_convert.sv
// Module: top of the float-to-integer unit. Chooses the rounding mode,
// runs unpack and round, and registers result and flags with a
// one-cycle valid pipeline. Assumes strap_new_arch only changes while
// rst_n is low.
module f2i_convert
    import f2i_pkg::*;
#(
    parameter int CSR_W   = 32,
    parameter int NAN_BIT = 18,
    parameter int RM_LSB  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_new_arch,
    input  logic             in_valid,
    input  logic             in_src_dbl,
    input  logic             in_dst_long,
    input  logic [2:0]       in_kind,
    input  logic [XLEN-1:0]  in_operand,
    input  logic             csr_we,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_result,
    output logic             out_invalid,
    output logic             out_inexact
);
    localparam logic [XLEN-1:0] LEG_PAT_L = {1'b0, {(XLEN-1){1'b1}}};
    localparam logic [XLEN-1:0] LEG_PAT_W = {{(XLEN-WORD_W){1'b0}}, 1'b0, {(WORD_W-1){1'b1}}};

    logic [CSR_W-1:0] csr_q;
    unpacked_t        unp;
    rmode_e           rm;
    logic [XLEN-1:0]  c_result;
    logic             c_invalid, c_inexact;
    logic             dst_q;

    f2i_csr #(.CSR_W(CSR_W), .NAN_BIT(NAN_BIT)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_new (strap_new_arch),
        .we        (csr_we),
        .wdata     (csr_wdata),
        .q         (csr_q)
    );

    // Rounding mode: fixed kind, or the register field for kinds 4..7.
    always_comb begin
        rm = rmode_e'(in_kind[2] ? csr_q[RM_LSB +: 2] : in_kind[1:0]);
    end

    f2i_unpack u_unpack (
        .src_dbl (in_src_dbl),
        .operand (in_operand),
        .u       (unp)
    );

    f2i_round u_round (
        .u        (unp),
        .rm       (rm),
        .dst_long (in_dst_long),
        .nan2008  (csr_q[NAN_BIT]),
        .result   (c_result),
        .invalid  (c_invalid),
        .inexact  (c_inexact)
    );

    // Output stage: capture on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
            dst_q       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= c_result;
                out_invalid <= c_invalid;
                out_inexact <= c_inexact;
                dst_q       <= in_dst_long;
            end
        end
    end

    assign csr_rdata = csr_q;

    p_valid_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_invalid) && $stable(out_inexact)));

    p_word_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !dst_q) |-> (out_result[XLEN-1:WORD_W] == '0));

    p_legacy_pattern_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid && !strap_new_arch) |->
            (out_result == (dst_q ? LEG_PAT_L : LEG_PAT_W)));

    p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));
endmodule

// File: tb/f2i_convert_tb.sv
module f2i_convert_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_src_dbl = 1'b0;
    logic        in_dst_long = 1'b0;
    logic [2:0]  in_kind = '0;
    logic [63:0] in_operand = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_invalid;
    logic        out_inexact;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] csr_model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    f2i_convert u_dut (
        .clk(clk), .rst_n(rst_n), .strap_new_arch(strap),
        .in_valid(in_valid), .in_src_dbl(in_src_dbl), .in_dst_long(in_dst_long),
        .in_kind(in_kind), .in_operand(in_operand),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .out_valid(out_valid), .out_result(out_result),
        .out_invalid(out_invalid), .out_inexact(out_inexact)
    );

    function automatic bit bits_nan(bit dbl, logic [63:0] b);
        if (dbl) return (b[62:52] == 11'h7FF) && (b[51:0] != 0);
        return (b[30:23] == 8'hFF) && (b[22:0] != 0);
    endfunction

    function automatic bit bits_inf(bit dbl, logic [63:0] b);
        if (dbl) return (b[62:52] == 11'h7FF) && (b[51:0] == 0);
        return (b[30:23] == 8'hFF) && (b[22:0] == 0);
    endfunction

    function automatic real bits_real(bit dbl, logic [63:0] b);
        logic [10:0] ed;
        if (dbl) return $bitstoreal(b);
        if (b[30:23] == 8'h00)
            return (b[31] ? -1.0 : 1.0) * real'(b[22:0]) * (2.0 ** (-149));
        ed = 11'(int'(b[30:23]) + 896);
        return $bitstoreal({b[31], ed, b[22:0], 29'b0});
    endfunction

    // Reference: expected result and flags from the requirements.
    task automatic model(input bit dbl, input bit lng, input logic [1:0] rm,
                         input logic [63:0] b, input bit n08,
                         output logic [63:0] res, output bit inv, output bit inx);
        real x, f, d, h, r;
        bit neg;
        logic [63:0] ppos, pneg;
        ppos = lng ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
        pneg = lng ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
        neg  = dbl ? b[63] : b[31];
        inx = 1'b0;
        if (bits_nan(dbl, b)) begin
            inv = 1'b1; res = n08 ? 64'h0 : ppos; return;
        end
        if (bits_inf(dbl, b)) begin
            inv = 1'b1; res = (n08 && neg) ? pneg : ppos; return;
        end
        x = bits_real(dbl, b);
        case (rm)
            2'd0: begin
                f = $floor(x); d = x - f; r = f;
                if (d > 0.5) r = f + 1.0;
                else if (d == 0.5) begin
                    h = f / 2.0;
                    if (h != $floor(h)) r = f + 1.0;
                end
            end
            2'd1: r = (x < 0.0) ? $ceil(x) : $floor(x);
            2'd2: r = $ceil(x);
            default: r = $floor(x);
        endcase
        if (lng ? (r >= 2.0 ** 63) : (r > 2147483647.0)) begin
            inv = 1'b1; res = ppos; return;
        end
        if (lng ? (r < -(2.0 ** 63)) : (r < -2147483648.0)) begin
            inv = 1'b1; res = n08 ? pneg : ppos; return;
        end
        inv = 1'b0;
        inx = (r != x);
        if (lng) res = longint'(r);
        else     res = {32'h0, 32'(int'(r))};
    endtask

    task automatic check(string tag, bit ok, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Called at a falling edge; drives a request and samples one cycle later.
    task automatic conv(string tag, bit dbl, bit lng, logic [2:0] kind, logic [63:0] b);
        logic [63:0] er; bit ei, ex;
        logic [1:0] rm;
        rm = kind[2] ? csr_model[1:0] : kind[1:0];
        model(dbl, lng, rm, b, strap, er, ei, ex);
        in_valid = 1'b1; in_src_dbl = dbl; in_dst_long = lng;
        in_kind = kind; in_operand = b;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, (out_valid === 1'b1) && (out_result === er) &&
              (out_invalid === ei) && (out_inexact === ex), "result/valid/invalid/inexact",
              {out_result[60:0], out_valid, out_invalid, out_inexact},
              {er[60:0], 1'b1, ei, ex});
    endtask

    task automatic csr_wr(logic [31:0] d);
        logic [31:0] e;
        csr_we = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
        e = strap ? (d | 32'h0004_0000) : (d & ~32'h0004_0000);
        csr_model = e;
        check("R2", csr_rdata === e, "csr after write", {32'h0, csr_rdata}, {32'h0, e});
    endtask

    task automatic do_reset(bit s);
        logic [31:0] e;
        rst_n = 1'b0; strap = s; in_valid = 1'b0; csr_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e = s ? 32'h0004_0000 : 32'h0;
        csr_model = e;
        check("R1", csr_rdata === e, "csr reset value", {32'h0, csr_rdata}, {32'h0, e});
        check("R1", out_valid === 1'b0, "out_valid after reset", {63'h0, out_valid}, 64'h0);
    endtask

    function automatic logic [63:0] rnd_op(bit dbl);
        logic [63:0] b;
        int sel;
        sel = int'($urandom % 8);
        b = {$urandom, $urandom};
        if (sel == 0) return b;
        if (dbl) begin
            b[62:52] = 11'(1020 + ($urandom % 70));
            if (sel == 1) b[40:0] = '0;
        end else begin
            b[30:23] = 8'(124 + ($urandom % 70));
            if (sel == 1) b[12:0] = '0;
        end
        return b;
    endfunction

    task automatic random_phase(int n);
        for (int i = 0; i < n; i++) begin
            if (i % 100 == 0) csr_wr($urandom);
            conv("R4", 1'($urandom), 1'($urandom), 3'($urandom), rnd_op(1'b1));
            conv("R6", 1'b0, 1'($urandom), 3'($urandom), rnd_op(1'b0));
        end
    endtask

    initial begin
        logic [63:0] held;
        void'($urandom(32'd20151));
        @(negedge clk);
        do_reset(1'b0);

        // Legacy invalid handling.
        conv("R10", 1'b1, 1'b1, 3'd0, 64'h7FF8_0000_0000_0001);
        conv("R10", 1'b1, 1'b0, 3'd1, 64'hFFF0_0000_0000_0000);
        conv("R10", 1'b1, 1'b1, 3'd3, $realtobits(-1.0e30));
        conv("R10", 1'b1, 1'b0, 3'd1, $realtobits(-2147483649.0));
        conv("R10", 1'b0, 1'b0, 3'd0, 64'hDEAD_BEEF_FFC0_0000);
        csr_wr(32'hFFFF_FFFF);
        csr_wr(32'h0000_0001);
        random_phase(700);

        do_reset(1'b1);
        csr_wr(32'h0000_0000);

        // Rounding kinds.
        conv("R4", 1'b1, 1'b0, 3'd0, $realtobits(2.5));
        conv("R4", 1'b1, 1'b0, 3'd0, $realtobits(3.5));
        conv("R4", 1'b1, 1'b1, 3'd0, $realtobits(-2.5));
        conv("R4", 1'b1, 1'b0, 3'd1, $realtobits(-2.7));
        conv("R4", 1'b1, 1'b1, 3'd3, $realtobits(-2.3));
        conv("R4", 1'b1, 1'b0, 3'd2, $realtobits(2.1));
        conv("R4", 1'b0, 1'b0, 3'd2, 64'h0000_0000_3F00_0000);
        conv("R4", 1'b1, 1'b0, 3'd2, $realtobits(-0.3));
        // Register-driven mode.
        csr_wr(32'h0000_0003);
        conv("R5", 1'b1, 1'b0, 3'd4, $realtobits(-2.5));
        csr_wr(32'h0000_0002);
        conv("R5", 1'b1, 1'b0, 3'd7, $realtobits(-2.5));
        conv("R5", 1'b1, 1'b1, 3'd5, $realtobits(2.25));
        csr_wr(32'h0000_0000);
        // Single source and word placement.
        conv("R6", 1'b0, 1'b0, 3'd0, 64'hFFFF_FFFF_4020_0000);
        conv("R6", 1'b0, 1'b1, 3'd1, 64'h1234_5678_BFC0_0000);
        conv("R6", 1'b1, 1'b0, 3'd1, $realtobits(-5.0));
        // Inexact.
        conv("R7", 1'b1, 1'b1, 3'd0, $realtobits(2.0));
        conv("R7", 1'b1, 1'b1, 3'd0, $realtobits(2.25));
        // 2008 NaN.
        conv("R8", 1'b1, 1'b1, 3'd0, 64'hFFF8_0000_0000_0000);
        conv("R8", 1'b0, 1'b0, 3'd3, 64'h0000_0000_7FC0_0000);
        // Saturation by sign.
        conv("R9", 1'b1, 1'b1, 3'd0, 64'h7FF0_0000_0000_0000);
        conv("R9", 1'b1, 1'b0, 3'd0, 64'hFFF0_0000_0000_0000);
        conv("R9", 1'b0, 1'b0, 3'd1, 64'h0000_0000_4F00_0000);
        conv("R9", 1'b0, 1'b0, 3'd1, 64'h0000_0000_CF00_0000);
        conv("R9", 1'b1, 1'b0, 3'd1, $realtobits(-2147483649.0));
        conv("R9", 1'b1, 1'b0, 3'd3, $realtobits(-2147483648.5));
        conv("R9", 1'b1, 1'b0, 3'd1, $realtobits(-2147483648.5));
        conv("R9", 1'b1, 1'b1, 3'd0, 64'h43E0_0000_0000_0000);
        conv("R9", 1'b1, 1'b1, 3'd0, 64'hC3E0_0000_0000_0000);
        // Invalid masks inexact.
        conv("R11", 1'b1, 1'b0, 3'd1, $realtobits(3000000000.5));

        // Hold when idle.
        held = out_result;
        @(negedge clk);
        check("R3", (out_valid === 1'b0) && (out_result === held), "idle hold",
              {out_result[62:0], out_valid}, {held[62:0], 1'b0});

        random_phase(700);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule